// File: doc/BRIEF.md
# Status Register Write Protection Unit

This unit sits beside the command decoder of a serial nonvolatile memory. It owns the one-byte status word. That word holds a write-enable latch, a busy flag, a two-bit protected-region selector and a lock bit for the status register itself. The decoder sends single-cycle strobes: enable, disable, status write with a data byte, write-cycle start and write-cycle done. It also presents the address of a pending array byte write.

The unit answers with two combinational grants. One says whether a status write may be committed now. The other says whether the presented array address may be written. Both grants also depend on the external write-protect pin.

The lock bit and region bits model nonvolatile cells. They are held in plain registers that power up at zero and that a synchronous reset leaves untouched. While a write cycle runs, those three bits read back their pre-cycle values, but the enable latch and the busy flag stay live.

Top module: `sr_wprot_unit`

## Requirements
- R1: `status_o` holds: bit 7 the lock bit, bits 6..4 always 0, bits 3..2 the region code, bit 1 the write-enable latch, bit 0 the busy flag.
- R2: After power-up `status_o` is 0x00. A reset clears the enable latch and the busy flag and leaves the lock and region bits unchanged.
- R3: An enable strobe sets the latch one cycle later. A disable strobe or a done strobe clears it. Clearing wins when a set and a clear arrive together.
- R4: `sts_grant_o` is 1 exactly when the latch is set, no cycle is busy and hardware lock is off. A status write commits only when its request meets the grant. It takes data bits 7, 3 and 2, and the latch and busy bits ignore the data.
- R5: Hardware lock is on while the lock bit is 1 and `wp_n_i` is 0, whichever of the two became true last. Raising `wp_n_i` ends it without changing the region code.
- R6: Region code 00 protects nothing, 01 the top quarter of the address space, 10 the top half, and 11 every address. `arr_grant_o` is 0 for any protected address.
- R7: Outside the protected region, `arr_grant_o` is 1 only while the latch is set and no cycle is busy.
- R8: The busy flag rises one cycle after a start strobe and falls one cycle after a done strobe. Done wins if both arrive together.
- R9: While busy, bits 7 and 3..2 show the values they held when the cycle began, while bits 1 and 0 follow the live state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wp_n_i | input | 1 | External write-protect pin, low asserts protection |
| wren_i | input | 1 | Set-enable strobe |
| wrdi_i | input | 1 | Clear-enable strobe |
| sts_req_i | input | 1 | Status write request |
| sts_data_i | input | 8 | Status byte offered with the request |
| arr_addr_i | input | ADDR_W | Array address to be checked |
| cyc_start_i | input | 1 | Internal write cycle begins |
| cyc_done_i | input | 1 | Internal write cycle ends |
| status_o | output | 8 | Readable status byte |
| sts_grant_o | output | 1 | Status write allowed now |
| arr_grant_o | output | 1 | Write to `arr_addr_i` allowed now |

## Verification
Both grants are combinational, so they are due in the same cycle as the inputs that set them. The bench samples them one time unit after driving at the falling edge, before any clock edge. Every status bit comes from a register and is due after exactly one rising edge. The bench reads `status_o` one time unit after that edge, before the next stimulus is applied. The freeze during a busy cycle, and the choice of winner when strobes coincide, are checked at that same one-edge point.

// File: rtl/sr_wprot_pkg.sv
package sr_wprot_pkg;

    localparam int STS_W = 8;

    typedef enum logic [1:0] {
        SPAN_NONE    = 2'b00,
        SPAN_QUARTER = 2'b01,
        SPAN_HALF    = 2'b10,
        SPAN_ALL     = 2'b11
    } prot_span_e;

    // nonvolatile part of the status byte
    typedef struct packed {
        logic       lock_en;
        prot_span_e span;
    } nv_bits_t;

    function automatic logic [STS_W-1:0] pack_status(nv_bits_t nv, logic wel, logic wip);
        return {nv.lock_en, 3'b000, nv.span, wel, wip};
    endfunction

    function automatic nv_bits_t unpack_nv(logic [STS_W-1:0] d);
        nv_bits_t r;
        r.lock_en = d[7];
        r.span    = prot_span_e'(d[3:2]);
        return r;
    endfunction

endpackage

// File: rtl/sr_wprot_latch.sv
module sr_wprot_latch (
    input  logic clk,
    input  logic rst,
    input  logic set_en_i,
    input  logic clr_en_i,
    input  logic start_i,
    input  logic done_i,
    output logic wel_o,
    output logic busy_o
);
    logic wel_q;
    logic busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            wel_q  <= 1'b0;
            busy_q <= 1'b0;
        end else begin
            if (clr_en_i || done_i)
                wel_q <= 1'b0;
            else if (set_en_i)
                wel_q <= 1'b1;
            if (done_i)
                busy_q <= 1'b0;
            else if (start_i)
                busy_q <= 1'b1;
        end
    end

    assign wel_o  = wel_q;
    assign busy_o = busy_q;
endmodule

// File: rtl/sr_wprot_nvreg.sv
module sr_wprot_nvreg
    import sr_wprot_pkg::*;
(
    input  logic     clk,
    input  logic     commit_i,
    input  nv_bits_t new_i,
    input  logic     busy_i,
    output nv_bits_t live_o,
    output nv_bits_t shown_o
);
    // power-up value models delivery state; reset does not touch these
    nv_bits_t nv_q   = '0;
    nv_bits_t snap_q = '0;

    always_ff @(posedge clk) begin
        if (commit_i)
            nv_q <= new_i;
        if (!busy_i)
            snap_q <= nv_q;
    end

    assign live_o  = nv_q;
    assign shown_o = busy_i ? snap_q : nv_q;
endmodule

// File: rtl/sr_wprot_region.sv
module sr_wprot_region
    import sr_wprot_pkg::*;
#(
    parameter int ADDR_W = 15
) (
    input  prot_span_e        span_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              hit_o
);
    localparam int TOP = ADDR_W - 1;

    always_comb begin
        unique case (span_i)
            SPAN_NONE:    hit_o = 1'b0;
            SPAN_QUARTER: hit_o = addr_i[TOP] & addr_i[TOP-1];
            SPAN_HALF:    hit_o = addr_i[TOP];
            default:      hit_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/sr_wprot_unit.sv
module sr_wprot_unit
    import sr_wprot_pkg::*;
#(
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wp_n_i,
    input  logic              wren_i,
    input  logic              wrdi_i,
    input  logic              sts_req_i,
    input  logic [STS_W-1:0]  sts_data_i,
    input  logic [ADDR_W-1:0] arr_addr_i,
    input  logic              cyc_start_i,
    input  logic              cyc_done_i,
    output logic [STS_W-1:0]  status_o,
    output logic              sts_grant_o,
    output logic              arr_grant_o
);
    logic     wel;
    logic     busy;
    logic     hw_lock;
    logic     region_hit;
    logic     commit;
    nv_bits_t nv_live;
    nv_bits_t nv_shown;

    sr_wprot_latch u_latch (
        .clk      (clk),
        .rst      (rst),
        .set_en_i (wren_i),
        .clr_en_i (wrdi_i),
        .start_i  (cyc_start_i),
        .done_i   (cyc_done_i),
        .wel_o    (wel),
        .busy_o   (busy)
    );

    sr_wprot_nvreg u_nv (
        .clk      (clk),
        .commit_i (commit),
        .new_i    (unpack_nv(sts_data_i)),
        .busy_i   (busy),
        .live_o   (nv_live),
        .shown_o  (nv_shown)
    );

    sr_wprot_region #(.ADDR_W(ADDR_W)) u_region (
        .span_i (nv_live.span),
        .addr_i (arr_addr_i),
        .hit_o  (region_hit)
    );

    assign hw_lock     = nv_live.lock_en & ~wp_n_i;
    assign sts_grant_o = wel & ~busy & ~hw_lock;
    assign commit      = sts_req_i & sts_grant_o;
    assign arr_grant_o = wel & ~busy & ~region_hit;
    assign status_o    = pack_status(nv_shown, wel, busy);
endmodule

// File: rtl/sr_wprot_chk.sv
module sr_wprot_chk #(
    parameter int ADDR_W = 15
) (
    input logic              clk,
    input logic              rst,
    input logic              wp_n_i,
    input logic              wren_i,
    input logic              wrdi_i,
    input logic              cyc_start_i,
    input logic              cyc_done_i,
    input logic [7:0]        status_o,
    input logic              sts_grant_o,
    input logic              arr_grant_o,
    input logic [ADDR_W-1:0] arr_addr_i
);
    assert_unused_zero_R1: assert property (@(posedge clk) disable iff (rst)
        status_o[6:4] == 3'b000);

    assert_disable_clears_R3: assert property (@(posedge clk) disable iff (rst)
        wrdi_i |=> !status_o[1]);

    assert_enable_sets_R3: assert property (@(posedge clk) disable iff (rst)
        (wren_i && !wrdi_i && !cyc_done_i) |=> status_o[1]);

    assert_grant_needs_wel_R4: assert property (@(posedge clk) disable iff (rst)
        sts_grant_o |-> (status_o[1] && !status_o[0]));

    assert_hw_lock_R5: assert property (@(posedge clk) disable iff (rst)
        (status_o[7] && !status_o[0] && !wp_n_i) |-> !sts_grant_o);

    assert_whole_span_R6: assert property (@(posedge clk) disable iff (rst)
        (!status_o[0] && status_o[3:2] == 2'b11) |-> !arr_grant_o);

    assert_done_idle_R8: assert property (@(posedge clk) disable iff (rst)
        cyc_done_i |=> (!status_o[0] && !status_o[1]));

    assert_start_busy_R8: assert property (@(posedge clk) disable iff (rst)
        (cyc_start_i && !cyc_done_i) |=> status_o[0]);

    assert_frozen_nv_R9: assert property (@(posedge clk) disable iff (rst)
        (status_o[0] && $past(status_o[0])) |-> $stable({status_o[7], status_o[3:2]}));
endmodule

bind sr_wprot_unit sr_wprot_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .wp_n_i      (wp_n_i),
    .wren_i      (wren_i),
    .wrdi_i      (wrdi_i),
    .cyc_start_i (cyc_start_i),
    .cyc_done_i  (cyc_done_i),
    .status_o    (status_o),
    .sts_grant_o (sts_grant_o),
    .arr_grant_o (arr_grant_o),
    .arr_addr_i  (arr_addr_i)
);

// File: tb/sr_wprot_unit_tb_top.sv
module sr_wprot_unit_tb_top;
    localparam int CLK_P  = 10;
    localparam int ADDR_W = 15;
    localparam int NV     = 27;

    typedef struct packed {
        logic [3:0]  rq;
        logic        wp;
        logic        en;
        logic        dis;
        logic        req;
        logic [7:0]  data;
        logic [15:0] addr;
        logic        start;
        logic        done;
        logic        esg;
        logic        eag;
        logic [7:0]  est;
    } vec_t;

    function automatic vec_t mk(logic [3:0] rq, logic wp, logic en, logic dis, logic req,
                                logic [7:0] data, logic [15:0] addr, logic start, logic done,
                                logic esg, logic eag, logic [7:0] est);
        vec_t v;
        v = '{rq, wp, en, dis, req, data, addr, start, done, esg, eag, est};
        return v;
    endfunction

    // fields: req tag, wp_n, wren, wrdi, sts req, data, addr, start, done, exp sgrant, exp agrant, exp status
    localparam vec_t VECS [0:NV-1] = '{
        mk(2, 1,0,0,0, 8'h00, 16'h7FFF, 0,0, 0,0, 8'h00), // R2 idle
        mk(3, 1,1,0,0, 8'h00, 16'h7FFF, 0,0, 0,0, 8'h02), // R3 set
        mk(7, 1,0,0,0, 8'h00, 16'h7FFF, 0,0, 1,1, 8'h02), // R7
        mk(9, 1,0,0,1, 8'hFF, 16'h7FFF, 1,0, 1,1, 8'h03), // R4 R9 commit+start, old nv shown
        mk(9, 1,0,0,0, 8'h00, 16'h7FFF, 0,0, 0,0, 8'h03), // R9 busy
        mk(9, 1,0,1,0, 8'h00, 16'h7FFF, 0,0, 0,0, 8'h01), // R9 live WEL
        mk(9, 1,1,0,0, 8'h00, 16'h7FFF, 0,0, 0,0, 8'h03), // R9
        mk(8, 1,0,0,0, 8'h00, 16'h7FFF, 0,1, 0,0, 8'h8C), // R8 done
        mk(3, 1,1,0,0, 8'h00, 16'h7FFF, 0,0, 0,0, 8'h8E), // R3
        mk(5, 0,0,0,0, 8'h00, 16'h0000, 0,0, 0,0, 8'h8E), // R5 lock, R6 all
        mk(5, 0,0,0,1, 8'h00, 16'h0000, 0,0, 0,0, 8'h8E), // R5 refused
        mk(5, 1,0,0,0, 8'h00, 16'h0000, 0,0, 1,0, 8'h8E), // R5 release, BP kept
        mk(4, 1,0,0,1, 8'h04, 16'h0000, 0,0, 1,0, 8'h06), // R4
        mk(6, 1,0,0,0, 8'h00, 16'h5FFF, 0,0, 1,1, 8'h06), // R6 quarter edge
        mk(6, 1,0,0,0, 8'h00, 16'h6000, 0,0, 1,0, 8'h06), // R6
        mk(6, 1,0,0,1, 8'h08, 16'h7FFF, 0,0, 1,0, 8'h0A), // R6
        mk(6, 1,0,0,0, 8'h00, 16'h3FFF, 0,0, 1,1, 8'h0A), // R6 half edge
        mk(6, 1,0,0,0, 8'h00, 16'h4000, 0,0, 1,0, 8'h0A), // R6
        mk(4, 1,0,0,1, 8'h80, 16'h0000, 0,0, 1,1, 8'h82), // R4
        mk(5, 0,0,0,0, 8'h00, 16'h7FFF, 0,0, 0,1, 8'h82), // R5 lock bit first
        mk(3, 0,1,1,0, 8'h00, 16'h7FFF, 0,0, 0,1, 8'h80), // R3 clear wins
        mk(3, 0,1,0,0, 8'h00, 16'h7FFF, 0,0, 0,0, 8'h82), // R3
        mk(4, 1,0,0,1, 8'h00, 16'h7FFF, 0,0, 1,1, 8'h02), // R4
        mk(5, 0,0,0,1, 8'h80, 16'h7FFF, 0,0, 1,1, 8'h82), // R5 pin first
        mk(5, 0,0,0,0, 8'h00, 16'h7FFF, 0,0, 0,1, 8'h82), // R5
        mk(8, 0,0,0,0, 8'h00, 16'h7FFF, 1,0, 0,1, 8'h83), // R8
        mk(8, 0,1,0,0, 8'h00, 16'h7FFF, 0,1, 0,0, 8'h80)  // R8 R3 done beats set
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wp_n = 1'b1;
    logic              wren = 1'b0;
    logic              wrdi = 1'b0;
    logic              sreq = 1'b0;
    logic [7:0]        sdata = '0;
    logic [ADDR_W-1:0] addr = '0;
    logic              cstart = 1'b0;
    logic              cdone = 1'b0;
    logic [7:0]        status;
    logic              sgrant;
    logic              agrant;
    int                n_run = 0;
    int                n_fail = 0;
    logic              finished = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    sr_wprot_unit #(.ADDR_W(ADDR_W)) dut_i (
        .clk(clk), .rst(rst), .wp_n_i(wp_n), .wren_i(wren), .wrdi_i(wrdi),
        .sts_req_i(sreq), .sts_data_i(sdata), .arr_addr_i(addr),
        .cyc_start_i(cstart), .cyc_done_i(cdone),
        .status_o(status), .sts_grant_o(sgrant), .arr_grant_o(agrant)
    );

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic clear_strobes();
        wren = 0; wrdi = 0; sreq = 0; cstart = 0; cdone = 0;
    endtask

    initial begin
        repeat (2) @(posedge clk);
        #1 rst = 1'b0;
        check("R2 power-up status", status, 8'h00);
        check("R1 unused bits", {5'd0, status[6:4]}, 8'h00);
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            wp_n = VECS[i].wp; wren = VECS[i].en; wrdi = VECS[i].dis;
            sreq = VECS[i].req; sdata = VECS[i].data; addr = VECS[i].addr[ADDR_W-1:0];
            cstart = VECS[i].start; cdone = VECS[i].done;
            #1;
            check($sformatf("R%0d vec %0d sts grant", VECS[i].rq, i), {7'd0, sgrant}, {7'd0, VECS[i].esg});
            check($sformatf("R%0d vec %0d arr grant", VECS[i].rq, i), {7'd0, agrant}, {7'd0, VECS[i].eag});
            @(posedge clk);
            #1;
            clear_strobes();
            check($sformatf("R%0d vec %0d status", VECS[i].rq, i), status, VECS[i].est);
        end
        // R2: reset mid-cycle keeps nonvolatile bits, clears WEL and WIP
        @(negedge clk); wp_n = 1; wren = 1;
        @(posedge clk); #1 clear_strobes();
        check("R3 set before reset", status, 8'h82);
        @(negedge clk); cstart = 1;
        @(posedge clk); #1 clear_strobes();
        check("R8 busy before reset", status, 8'h83);
        @(negedge clk); rst = 1;
        @(posedge clk); #1 rst = 0;
        check("R2 reset keeps lock bit", status, 8'h80);
        check("R1 unused bits after run", {5'd0, status[6:4]}, 8'h00);
        finished = 1'b1;
    end

    initial begin
        fork
            wait (finished);
            begin
                repeat (2000) @(posedge clk);
                n_run++; n_fail++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule